// File: doc/BRIEF.md
# DRAM Secure Region Filter

This block sits on the address path in front of a DRAM controller and decides, for every request, whether the requester may reach the addressed location. Software marks up to eight address windows as secure-only. Each window has a start and an end expressed as megabyte indices. One control setting marks all remaining memory as secure, and a global switch turns every check off. A request carries its address and a secure/non-secure attribute. One cycle later the block answers with either a grant or an error.

Configuration goes through a small 32-bit register file. Each write carries its own per-bit enable in the upper half-word, so software can change single fields without a read-modify-write. A denied request sets a sticky violation flag and records the offending address, which lets the secure software find out what was blocked. The memory controller, bus protocol handling and per-master filtering are outside this block.

Top module: `ddr_sec_filter`

## Requirements
- R1: After synchronous reset, all region bounds read 0, all region enables are clear and the bypass bit is set, so the control register (index 16) reads 0x0000_0200. Every request is granted, and the violation flag (index 17, bit 0) reads 0.
- R2: On a register write, bit k of the lower half-word (k in 0..15) is stored only when bit k+16 of the same word is 1. All other stored bits keep their value. Reads return a stored 16-bit register zero-extended to 32 bits.
- R3: Index n (0..7) holds the start megabyte of region n, and index n+8 holds its end megabyte. A request lies in region n when its address bits [31:20] are at least the start and at most the end, both bounds inclusive. Start = end = m covers exactly megabyte m.
- R4: Control bits 0..7 enable regions 0..7. A region whose enable is 0 has no effect on any decision.
- R5: When control bit 8 is set, every address outside all enabled regions is secure-only.
- R6: When control bit 9 is set, every request is granted whatever the other settings are.
- R7: A request with the secure attribute is always granted. A non-secure request is refused only when bypass is clear and its address lies in an enabled region, or lies outside all enabled regions while bit 8 is set.
- R8: A request presented with req_valid in one cycle is answered in the next cycle with rsp_valid high and exactly one of rsp_ok and rsp_err high. A decision uses the configuration held before any write in the same cycle.
- R9: A refusal sets a sticky flag, visible on viol_flag and at index 17 bit 0, in the same cycle that rsp_err rises. The flag clears only on a write to index 17 with bit 0 and bit 16 both 1.
- R10: The address of the first refusal is captured and held while the flag stays set, even if later refusals occur. It is visible on viol_addr and at index 18.
- R11: If a clearing write to index 17 and a new refusal fall in the same cycle, the flag stays set and the new refusal's address is captured.
- R12: cfg_rdata shows, one cycle after cfg_idx is presented, the register that cfg_idx selects. Unused indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Register index for write and read |
| cfg_wdata | input | 32 | Write word: upper half is the bit enable, lower half is the data |
| cfg_rdata | output | 32 | Registered read data for cfg_idx |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_secure | input | 1 | 1 = secure requester |
| rsp_valid | output | 1 | Decision valid |
| rsp_ok | output | 1 | Request granted |
| rsp_err | output | 1 | Request refused (error) |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | 32 | Captured address of the first refusal |

## Verification
Two functions of the block can act in the same cycle: software clearing the violation flag, and the decision logic setting that flag again for a new refusal. The bench first provokes a refusal. It then presents a clearing write to index 17 and a second non-secure request into a secure megabyte on the same clock edge. The test passes when the flag remains set and the captured address has moved to the second request. Region decisions are also swept over every megabyte index from 0 to 63 and over the top megabyte, in both secure modes, under several region, outside and bypass settings. Each answer is compared with an arithmetic model of the inclusive bounds.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;

  localparam int unsigned HALF_W = 16;

  // Masked update: upper half of the word enables lower-half bits.
  function automatic logic [HALF_W-1:0] mask_merge(input logic [HALF_W-1:0] old_v,
                                                   input logic [2*HALF_W-1:0] word);
    logic [HALF_W-1:0] m;
    m = word[2*HALF_W-1:HALF_W];
    return (old_v & ~m) | (word[HALF_W-1:0] & m);
  endfunction

endpackage

// File: rtl/sec_rgn_regs.sv
module sec_rgn_regs
  import sec_filter_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int REG_AW  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [REG_AW-1:0]         idx,
  input  logic [31:0]               wdata,
  output logic [NUM_RGN*HALF_W-1:0] lo_flat,
  output logic [NUM_RGN*HALF_W-1:0] hi_flat,
  output logic [HALF_W-1:0]         ctrl
);

  localparam int CTRL_IDX = 2 * NUM_RGN;
  localparam logic [HALF_W-1:0] CTRL_RST = HALF_W'(1) << (NUM_RGN + 1);

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] hi_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (we) begin
        if (idx == REG_AW'(g))
          lo_q <= mask_merge(lo_q, wdata);
        if (idx == REG_AW'(g + NUM_RGN))
          hi_q <= mask_merge(hi_q, wdata);
      end
    end

    assign lo_flat[g*HALF_W +: HALF_W] = lo_q;
    assign hi_flat[g*HALF_W +: HALF_W] = hi_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl <= CTRL_RST;
    else if (we && idx == REG_AW'(CTRL_IDX))
      ctrl <= mask_merge(ctrl, wdata);
  end

endmodule

// File: rtl/sec_rgn_match.sv
module sec_rgn_match
  import sec_filter_pkg::*;
#(
  parameter int NUM_RGN = 8,
  parameter int IDX_W   = 12
) (
  input  logic [IDX_W-1:0]          mb,
  input  logic [NUM_RGN*HALF_W-1:0] lo_flat,
  input  logic [NUM_RGN*HALF_W-1:0] hi_flat,
  input  logic [NUM_RGN-1:0]        en,
  output logic                      hit_any
);

  logic [NUM_RGN-1:0] hit;

  for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
    logic [IDX_W-1:0] lo_v;
    logic [IDX_W-1:0] hi_v;
    assign lo_v   = lo_flat[g*HALF_W +: IDX_W];
    assign hi_v   = hi_flat[g*HALF_W +: IDX_W];
    assign hit[g] = en[g] && (mb >= lo_v) && (mb <= hi_v);
  end

  assign hit_any = |hit;

endmodule

// File: rtl/sec_viol_log.sv
module sec_viol_log #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              deny,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr,
  output logic              flag,
  output logic [ADDR_W-1:0] addr_q
);

  logic flag_eff;
  assign flag_eff = flag && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      addr_q <= '0;
    end else begin
      flag <= flag_eff || deny;
      if (deny && !flag_eff)
        addr_q <= addr;
    end
  end

endmodule

// File: rtl/ddr_sec_filter.sv
module ddr_sec_filter
  import sec_filter_pkg::*;
#(
  parameter  int NUM_RGN  = 8,
  parameter  int ADDR_W   = 32,
  parameter  int GRAN_LSB = 20,
  localparam int REG_AW   = $clog2(2 * NUM_RGN + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_err,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr
);

  localparam int IDX_W     = ADDR_W - GRAN_LSB;
  localparam int CTRL_IDX  = 2 * NUM_RGN;
  localparam int STAT_IDX  = CTRL_IDX + 1;
  localparam int VADDR_IDX = CTRL_IDX + 2;
  localparam int OUT_BIT   = NUM_RGN;
  localparam int BYP_BIT   = NUM_RGN + 1;

  logic [NUM_RGN*HALF_W-1:0] lo_flat;
  logic [NUM_RGN*HALF_W-1:0] hi_flat;
  logic [HALF_W-1:0]         ctrl;
  logic                      hit_any;
  logic                      bypass_w;
  logic                      outside_w;
  logic                      deny_c;
  logic                      clr_c;
  logic [31:0]               rd_c;

  sec_rgn_regs #(.NUM_RGN(NUM_RGN), .REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .lo_flat(lo_flat), .hi_flat(hi_flat), .ctrl(ctrl)
  );

  sec_rgn_match #(.NUM_RGN(NUM_RGN), .IDX_W(IDX_W)) u_match (
    .mb(req_addr[ADDR_W-1:GRAN_LSB]), .lo_flat(lo_flat), .hi_flat(hi_flat),
    .en(ctrl[NUM_RGN-1:0]), .hit_any(hit_any)
  );

  assign bypass_w  = ctrl[BYP_BIT];
  assign outside_w = ctrl[OUT_BIT];
  assign deny_c    = req_valid && !req_secure && !bypass_w && (hit_any || outside_w);
  assign clr_c     = cfg_we && (cfg_idx == REG_AW'(STAT_IDX)) && cfg_wdata[16] && cfg_wdata[0];

  sec_viol_log #(.ADDR_W(ADDR_W)) u_log (
    .clk(clk), .rst(rst), .deny(deny_c), .addr(req_addr), .clr(clr_c),
    .flag(viol_flag), .addr_q(viol_addr)
  );

  always_comb begin
    rd_c = '0;
    for (int i = 0; i < NUM_RGN; i++) begin
      if (cfg_idx == REG_AW'(i))
        rd_c = {16'h0, lo_flat[i*HALF_W +: HALF_W]};
      if (cfg_idx == REG_AW'(i + NUM_RGN))
        rd_c = {16'h0, hi_flat[i*HALF_W +: HALF_W]};
    end
    if (cfg_idx == REG_AW'(CTRL_IDX))
      rd_c = {16'h0, ctrl};
    if (cfg_idx == REG_AW'(STAT_IDX))
      rd_c = {31'h0, viol_flag};
    if (cfg_idx == REG_AW'(VADDR_IDX))
      rd_c = 32'(viol_addr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid && !deny_c;
      rsp_err   <= deny_c;
      cfg_rdata <= rd_c;
    end
  end

endmodule

// File: rtl/sec_filter_chk.sv
module sec_filter_chk #(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 5,
  parameter int NUM_RGN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [REG_AW-1:0] cfg_idx,
  input logic [31:0]       cfg_wdata,
  input logic              req_valid,
  input logic              req_secure,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              rsp_err,
  input logic              viol_flag,
  input logic [ADDR_W-1:0] viol_addr,
  input logic              bypass
);

  logic clr;
  assign clr = cfg_we && (cfg_idx == REG_AW'(2 * NUM_RGN + 1)) && cfg_wdata[16] && cfg_wdata[0];

  // R8: every request is answered one cycle later
  p_answer_next_r8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R8: an answer is a grant or an error, never both
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_ok ^ rsp_err));

  // R7: secure requesters are always granted
  p_secure_grant_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_secure) |=> rsp_ok);

  // R6: nothing is refused while bypass is set
  p_bypass_open_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bypass) |=> !rsp_err);

  // R9: an error is always accompanied by the flag
  p_err_flags_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> viol_flag);

  // R9: flag stays set without a clearing write
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !clr) |=> viol_flag);

  // R10: captured address held while the flag stays set
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (viol_flag && !clr) |=> $stable(viol_addr));

endmodule

bind ddr_sec_filter sec_filter_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .NUM_RGN(NUM_RGN)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
  .req_valid(req_valid), .req_secure(req_secure), .rsp_valid(rsp_valid),
  .rsp_ok(rsp_ok), .rsp_err(rsp_err), .viol_flag(viol_flag), .viol_addr(viol_addr),
  .bypass(bypass_w)
);

// File: tb/sim_ddr_sec_filter.sv
module sim_ddr_sec_filter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_secure = 1'b0;
  logic        rsp_valid, rsp_ok, rsp_err, viol_flag;
  logic [31:0] viol_addr;

  int n_checks = 0;
  int n_fail = 0;

  // bench model of the configuration
  int   m_lo [8];
  int   m_hi [8];
  logic [7:0] m_en = '0;
  logic m_out = 1'b0;
  logic m_byp = 1'b1;
  logic e_flag = 1'b0;
  logic [31:0] e_vaddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_sec_filter u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .viol_flag(viol_flag), .viol_addr(viol_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic exp_deny(input logic [11:0] mb, input logic sec);
    logic hit;
    if (sec || m_byp) return 1'b0;
    hit = 1'b0;
    for (int i = 0; i < 8; i++)
      if (m_en[i] && int'(mb) >= m_lo[i] && int'(mb) <= m_hi[i]) hit = 1'b1;
    return hit || m_out;
  endfunction

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx == 17 && d[16] && d[0]) e_flag = 1'b0;
  endtask

  task automatic rd(input string req, input int idx, input logic [31:0] exp);
    @(negedge clk);
    cfg_idx = 5'(idx);
    @(negedge clk);
    chk(req, cfg_rdata, exp);
  endtask

  task automatic access(input string req, input logic [31:0] a, input logic sec);
    logic d;
    d = exp_deny(a[31:20], sec);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_secure = sec;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req, {29'h0, rsp_valid, rsp_ok, rsp_err}, {29'h0, 1'b1, !d, d});
    if (d) begin
      if (!e_flag) e_vaddr = a;
      e_flag = 1'b1;
    end
  endtask

  task automatic sweep(input string req);
    for (int mb = 0; mb < 64; mb++) begin
      access(req, {12'(mb), 20'h5A3C1}, 1'b0);
      access(req, {12'(mb), 20'h00000}, 1'b1);
    end
    access(req, 32'hFFFF_FFFF, 1'b0);
    access(req, 32'hFFF0_0000, 1'b1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_lo[i] = 0; m_hi[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R12: reset state
    rd("R1 ctrl", 16, 32'h0000_0200);
    rd("R1 flag", 17, 32'h0);
    rd("R1 start0", 0, 32'h0);
    rd("R12 unused", 20, 32'h0);
    chk("R1 idle rsp", {31'h0, rsp_valid}, 32'h0);
    access("R1 bypass grant", 32'h0000_0000, 1'b0);
    access("R1 bypass grant", 32'h8123_4567, 1'b0);

    // R2: write mask
    wr(16, 32'h0000_FFFF);
    rd("R2 no mask", 16, 32'h0000_0200);
    wr(0, 32'h00FF_1234);
    rd("R2 partial", 0, 32'h0000_0034);
    wr(0, 32'hFFFF_0000);
    rd("R2 full clear", 0, 32'h0);

    // regions: 0 -> [0,31], 3 -> [40,40], 5 -> [50,55] left disabled
    wr(8, {16'hFFFF, 16'd31});  m_hi[0] = 31;
    rd("R2 end0", 8, 32'd31);
    wr(3, {16'hFFFF, 16'd40});  m_lo[3] = 40;
    wr(11, {16'hFFFF, 16'd40}); m_hi[3] = 40;
    wr(5, {16'hFFFF, 16'd50});  m_lo[5] = 50;
    wr(13, {16'hFFFF, 16'd55}); m_hi[5] = 55;
    wr(16, {16'h03FF, 16'h0009}); m_en = 8'h09; m_byp = 1'b0;
    sweep("R3 R4 R7 regions");

    // R3: start = end = 0 covers the first megabyte only
    wr(8, {16'hFFFF, 16'd0}); m_hi[0] = 0;
    access("R3 first MB", 32'h000F_FFFF, 1'b0);
    access("R3 second MB", 32'h0010_0000, 1'b0);
    wr(8, {16'hFFFF, 16'd31}); m_hi[0] = 31;

    // R5: outside-regions secure
    wr(16, {16'h03FF, 16'h0109}); m_out = 1'b1;
    sweep("R5 outside");

    // R6: bypass overrides all
    wr(16, {16'h03FF, 16'h0309}); m_byp = 1'b1;
    sweep("R6 bypass");

    // R9 / R10 / R11: violation logging
    wr(16, {16'h03FF, 16'h0009}); m_byp = 1'b0; m_out = 1'b0;
    wr(17, 32'h0001_0001);
    rd("R9 cleared", 17, 32'h0);
    access("R9 deny A", 32'h0051_1110, 1'b0);
    chk("R9 flag port", {31'h0, viol_flag}, 32'h1);
    chk("R10 addr A", viol_addr, 32'h0051_1110);
    access("R10 deny B", 32'h00A2_2220, 1'b0);
    chk("R10 addr held", viol_addr, 32'h0051_1110);
    rd("R10 addr read", 18, 32'h0051_1110);
    wr(17, 32'h0000_0001);
    rd("R9 masked clear ignored", 17, 32'h1);
    wr(17, 32'h0001_0001);
    rd("R9 W1C", 17, 32'h0);
    chk("R9 model", {31'h0, e_flag}, 32'h0);
    access("R11 deny C", 32'h0073_3330, 1'b0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'd17; cfg_wdata = 32'h0001_0001;
    req_valid = 1'b1; req_addr = 32'h0284_4440; req_secure = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R11 err", {31'h0, rsp_err}, 32'h1);
    chk("R11 flag kept", {31'h0, viol_flag}, 32'h1);
    chk("R11 new addr", viol_addr, 32'h0284_4440);

    // R8: config write in the same cycle as a request uses old config
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'd16; cfg_wdata = {16'h03FF, 16'h0209};
    req_valid = 1'b1; req_addr = 32'h0010_0000; req_secure = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R8 old config", {30'h0, rsp_ok, rsp_err}, 32'h1);
    m_byp = 1'b1;
    access("R8 new config", 32'h0010_0000, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule